// File: doc/BRIEF.md
# Scoped Fence Controller

This block sits beside the write-combining store buffer and the L1 data cache of one compute unit. A fence arrives with a scope tag. The block then issues only the cache maintenance that the scope calls for and raises a one-cycle completion pulse when that work is finished. Stores gather in the write-combining buffer before they reach the L1. The cost of a fence therefore grows with its scope:

- A sub-group fence needs no cache work.
- A work-group fence drains the buffer.
- An NDRange fence drains the buffer, then flushes the L1 and then invalidates it.
- A system fence does everything an NDRange fence does and then waits for an acknowledgement from the next memory level.

The block handles one fence at a time. Scope codes run from narrow to wide: 0 is sub-group, 1 is work-group, 2 is NDRange and 3 is system. Each maintenance step is a request/done handshake. A request stays high until its partner returns done, and the following step starts on the next cycle.

The sequencer has six states:

- IDLE: ready for a fence.
- DRAIN: buffer drain requested.
- FLUSH: L1 write-back requested.
- INVAL: L1 invalidate requested.
- NEXT: waiting for the next-level acknowledgement.
- DONE: completion pulse.

Its transitions are:

- IDLE to DONE on accepting a sub-group fence.
- IDLE to DRAIN on accepting any wider fence.
- DRAIN to DONE on drain_done when the scope is work-group.
- DRAIN to FLUSH on drain_done otherwise.
- FLUSH to INVAL on flush_done.
- INVAL to DONE on inval_done when the scope is NDRange.
- INVAL to NEXT on inval_done when the scope is system.
- NEXT to DONE on next_ack.
- DONE to IDLE unconditionally.

Top module: `scoped_fence_ctrl`

## Requirements
- R1: While reset is held, and after it is released, fence_ready is 1, and every step request and fence_done are 0.
- R2: fence_ready is 1 only in IDLE. A fence is accepted on a clock edge where fence_valid and fence_ready are both 1. fence_ready stays 0 from acceptance up to and including the fence_done cycle, and fence_valid is ignored during that time.
- R3: A sub-group fence (scope 0) raises fence_done in the cycle after acceptance and raises no step request.
- R4: A work-group fence (scope 1) raises drain_req only.
- R5: An NDRange fence (scope 2) raises drain_req, then flush_req, then inval_req, in that order.
- R6: A system fence (scope 3) raises the three NDRange steps in the same order and then raises next_req.
- R7: Each request is held until its done input is sampled high. The next step's request rises in the following cycle. So if each partner answers d cycles after the request rises, the fence takes 1 + sum(d+1) cycles from acceptance to the fence_done cycle.
- R8: At most one of drain_req, flush_req, inval_req and next_req is high in any cycle.
- R9: fence_done is high for exactly one cycle, and fence_ready is 1 in the cycle after it.
- R10: A done or ack input that is asserted while its own request is low has no effect. In IDLE this means fence_ready stays 1 and no request or fence_done appears.
- R11: The scope is captured at acceptance. Changes to fence_scope while a fence is in progress do not alter its steps or its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fence_valid | input | 1 | Fence request present |
| fence_scope | input | 2 | Scope code: 0 sub-group, 1 work-group, 2 NDRange, 3 system |
| fence_ready | output | 1 | Block is idle and can accept a fence |
| drain_req | output | 1 | Drain the write-combining buffer |
| drain_done | input | 1 | Buffer drain finished |
| flush_req | output | 1 | Write back dirty L1 lines |
| flush_done | input | 1 | L1 write-back finished |
| inval_req | output | 1 | Invalidate the L1 |
| inval_done | input | 1 | L1 invalidate finished |
| next_req | output | 1 | Ask the next level to confirm visibility |
| next_ack | input | 1 | Next level confirmed |
| fence_done | output | 1 | One-cycle fence completion pulse |

## Verification
Two things are hardest to bring about from the ports. The first is a fence whose tag changes after acceptance. The second is a partner that answers at a different pace on each step. To cover both, the bench models each partner with its own programmable answer delay. It sweeps every scope against every mix of zero and non-zero delays on the four handshakes, which gives 64 fences. It also holds fence_valid high and forces fence_scope to the system code for the whole time a fence is in progress. A wrongly captured scope therefore shows up as an extra step or a longer latency. A separate phase drives every done input while the block is idle, so that a step entered out of turn would be visible.

// File: rtl/fence_pkg.sv
`timescale 1ns/1ps
package fence_pkg;
    localparam int SCOPE_W = 2;
    localparam int NSTEP   = 4;

    localparam int STEP_DRAIN = 0;
    localparam int STEP_FLUSH = 1;
    localparam int STEP_INVAL = 2;
    localparam int STEP_NEXT  = 3;

    typedef enum logic [SCOPE_W-1:0] {
        SCOPE_SUBGRP = 2'd0,
        SCOPE_WRKGRP = 2'd1,
        SCOPE_NDR    = 2'd2,
        SCOPE_SYS    = 2'd3
    } scope_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FLUSH,
        ST_INVAL,
        ST_NEXT,
        ST_DONE
    } fstate_e;

    // Narrowest scope at which a step becomes necessary.
    function automatic logic [SCOPE_W-1:0] step_min_scope(input int step);
        case (step)
            STEP_DRAIN: return SCOPE_WRKGRP;
            STEP_FLUSH: return SCOPE_NDR;
            STEP_INVAL: return SCOPE_NDR;
            default:    return SCOPE_SYS;
        endcase
    endfunction
endpackage

// File: rtl/fence_req_capture.sv
`timescale 1ns/1ps
module fence_req_capture
    import fence_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [SCOPE_W-1:0] scope_in,
    output logic [SCOPE_W-1:0] scope_eff
);
    logic [SCOPE_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (accept) begin
            held_q <= scope_in;
        end
    end

    // On the accepting cycle the plan must see the incoming tag.
    always_comb begin
        scope_eff = accept ? scope_in : held_q;
    end
endmodule

// File: rtl/fence_scope_plan.sv
`timescale 1ns/1ps
module fence_scope_plan
    import fence_pkg::*;
(
    input  logic [SCOPE_W-1:0] scope,
    output logic [NSTEP-1:0]   need
);
    for (genvar gi = 0; gi < NSTEP; gi++) begin : g_need
        localparam logic [SCOPE_W-1:0] MIN_SC = step_min_scope(gi);
        assign need[gi] = (scope >= MIN_SC);
    end
endmodule

// File: rtl/fence_seq_fsm.sv
`timescale 1ns/1ps
module fence_seq_fsm
    import fence_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fence_valid,
    input  logic [NSTEP-1:0] need,
    input  logic [NSTEP-1:0] step_done,
    output logic             accept,
    output logic             fence_ready,
    output logic [NSTEP-1:0] step_req,
    output logic             fence_done
);
    fstate_e state_q;
    fstate_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fence_valid) begin
                    state_d = need[STEP_DRAIN] ? ST_DRAIN : ST_DONE;
                end
            end
            ST_DRAIN: begin
                if (step_done[STEP_DRAIN]) begin
                    state_d = need[STEP_FLUSH] ? ST_FLUSH : ST_DONE;
                end
            end
            ST_FLUSH: begin
                if (step_done[STEP_FLUSH]) begin
                    state_d = need[STEP_INVAL] ? ST_INVAL : ST_DONE;
                end
            end
            ST_INVAL: begin
                if (step_done[STEP_INVAL]) begin
                    state_d = need[STEP_NEXT] ? ST_NEXT : ST_DONE;
                end
            end
            ST_NEXT: begin
                if (step_done[STEP_NEXT]) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        fence_ready = 1'b0;
        fence_done  = 1'b0;
        step_req    = '0;
        unique case (state_q)
            ST_IDLE:  fence_ready          = 1'b1;
            ST_DRAIN: step_req[STEP_DRAIN] = 1'b1;
            ST_FLUSH: step_req[STEP_FLUSH] = 1'b1;
            ST_INVAL: step_req[STEP_INVAL] = 1'b1;
            ST_NEXT:  step_req[STEP_NEXT]  = 1'b1;
            ST_DONE:  fence_done           = 1'b1;
            default:  fence_ready          = 1'b0;
        endcase
        accept = fence_ready && fence_valid;
    end
endmodule

// File: rtl/scoped_fence_ctrl.sv
`timescale 1ns/1ps
module scoped_fence_ctrl
    import fence_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fence_valid,
    input  logic [SCOPE_W-1:0] fence_scope,
    output logic               fence_ready,
    output logic               drain_req,
    input  logic               drain_done,
    output logic               flush_req,
    input  logic               flush_done,
    output logic               inval_req,
    input  logic               inval_done,
    output logic               next_req,
    input  logic               next_ack,
    output logic               fence_done
);
    logic               accept;
    logic [SCOPE_W-1:0] scope_eff;
    logic [NSTEP-1:0]   need;
    logic [NSTEP-1:0]   step_done;
    logic [NSTEP-1:0]   step_req;

    assign step_done[STEP_DRAIN] = drain_done;
    assign step_done[STEP_FLUSH] = flush_done;
    assign step_done[STEP_INVAL] = inval_done;
    assign step_done[STEP_NEXT]  = next_ack;

    assign drain_req = step_req[STEP_DRAIN];
    assign flush_req = step_req[STEP_FLUSH];
    assign inval_req = step_req[STEP_INVAL];
    assign next_req  = step_req[STEP_NEXT];

    fence_req_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .scope_in  (fence_scope),
        .scope_eff (scope_eff)
    );

    fence_scope_plan u_plan (
        .scope (scope_eff),
        .need  (need)
    );

    fence_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_valid (fence_valid),
        .need        (need),
        .step_done   (step_done),
        .accept      (accept),
        .fence_ready (fence_ready),
        .step_req    (step_req),
        .fence_done  (fence_done)
    );
endmodule

// File: rtl/scoped_fence_ctrl_chk.sv
`timescale 1ns/1ps
module scoped_fence_ctrl_chk
    import fence_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fence_valid,
    input logic [SCOPE_W-1:0] fence_scope,
    input logic               fence_ready,
    input logic               drain_req,
    input logic               drain_done,
    input logic               flush_req,
    input logic               flush_done,
    input logic               inval_req,
    input logic               inval_done,
    input logic               next_req,
    input logic               next_ack,
    input logic               fence_done
);
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req, flush_req, inval_req, next_req})); // R8

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ready |-> !(drain_req || flush_req || inval_req || next_req || fence_done)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> (!fence_done && fence_ready)); // R9

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !drain_done) |=> drain_req); // R7

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req); // R7

    AST_FLUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(drain_req)); // R5

    AST_INVAL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inval_req) |-> $past(flush_req)); // R5

    AST_NEXT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(next_req) |-> $past(inval_req)); // R6

    AST_SUBGRP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid && fence_ready && fence_scope == SCOPE_SUBGRP) |=> fence_done); // R3

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_ready && !fence_valid) |=> fence_ready); // R10
endmodule

bind scoped_fence_ctrl scoped_fence_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fence_valid (fence_valid),
    .fence_scope (fence_scope),
    .fence_ready (fence_ready),
    .drain_req   (drain_req),
    .drain_done  (drain_done),
    .flush_req   (flush_req),
    .flush_done  (flush_done),
    .inval_req   (inval_req),
    .inval_done  (inval_done),
    .next_req    (next_req),
    .next_ack    (next_ack),
    .fence_done  (fence_done)
);

// File: tb/scoped_fence_ctrl_tb.sv
`timescale 1ns/1ps
module scoped_fence_ctrl_tb;
    import fence_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               fence_valid;
    logic [SCOPE_W-1:0] fence_scope;
    logic               fence_ready;
    logic               drain_req, flush_req, inval_req, next_req;
    logic               drain_done, flush_done, inval_done, next_ack;
    logic               fence_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int dly [4];
    int cnt [4];
    logic       spur;
    logic [3:0] req_v;
    logic [3:0] dn;

    always #2.5 clk = ~clk;

    scoped_fence_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_valid (fence_valid),
        .fence_scope (fence_scope),
        .fence_ready (fence_ready),
        .drain_req   (drain_req),
        .drain_done  (drain_done),
        .flush_req   (flush_req),
        .flush_done  (flush_done),
        .inval_req   (inval_req),
        .inval_done  (inval_done),
        .next_req    (next_req),
        .next_ack    (next_ack),
        .fence_done  (fence_done)
    );

    assign req_v = {next_req, inval_req, flush_req, drain_req};

    // Partner models: answer dly[i] cycles after the request rises.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            cnt[i] <= req_v[i] ? cnt[i] + 1 : 0;
        end
    end

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            dn[i] = (req_v[i] && (cnt[i] == dly[i])) || spur;
        end
    end

    assign drain_done = dn[0];
    assign flush_done = dn[1];
    assign inval_done = dn[2];
    assign next_ack   = dn[3];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_fence(input int s, input int d0, input int d1, input int d2, input int d3);
        int  seq, exp_seq, cyc, exp_cyc, code, last, busy_bad, multi;
        bit  got;
        string tag;
        dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
        @(negedge clk);
        fence_valid = 1'b1;
        fence_scope = s[SCOPE_W-1:0];
        chk(fence_ready == 1'b1, "R2 ready before accept", int'(fence_ready), 1);
        seq = 0; last = 0; cyc = 0; busy_bad = 0; multi = 0; got = 0;
        for (int k = 0; k < 500 && !got; k++) begin
            @(negedge clk);
            fence_scope = SCOPE_SYS;   // R11: junk tag while busy
            cyc++;
            if (fence_ready) busy_bad++;
            if ($countones(req_v) > 1) multi++;
            code = drain_req ? 1 : flush_req ? 2 : inval_req ? 3 : next_req ? 4 : 0;
            if (code != 0 && code != last) seq = seq * 8 + code;
            last = code;
            if (fence_done) got = 1;
        end
        fence_valid = 1'b0;
        // expected step list and latency from the scope rules
        exp_seq = 0;
        exp_cyc = 1;
        for (int st = 0; st < 4; st++) begin
            int mins;
            mins = (st == 0) ? 1 : (st < 3) ? 2 : 3;
            if (s >= mins) begin
                exp_seq = exp_seq * 8 + st + 1;
                exp_cyc += dly[st] + 1;
            end
        end
        tag = (s == 0) ? "R3 sub-group steps" : (s == 1) ? "R4 work-group steps" :
              (s == 2) ? "R5 ndrange steps" : "R6 system steps";
        chk(got == 1'b1, "R9 fence_done seen", int'(got), 1);
        chk(seq == exp_seq, tag, seq, exp_seq);
        chk(cyc == exp_cyc, "R7 R11 latency", cyc, exp_cyc);
        chk(busy_bad == 0, "R2 ready low while busy", busy_bad, 0);
        chk(multi == 0, "R8 single request", multi, 0);
        @(negedge clk);
        chk(fence_done == 1'b0, "R9 done one cycle", int'(fence_done), 0);
        chk(fence_ready == 1'b1, "R9 ready after done", int'(fence_ready), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        fence_valid = 1'b0;
        fence_scope = '0;
        spur = 1'b0;
        for (int i = 0; i < 4; i++) dly[i] = 0;
        repeat (3) @(negedge clk);
        chk(fence_ready == 1'b1, "R1 ready in reset", int'(fence_ready), 1);
        chk(req_v == 4'b0 && !fence_done, "R1 quiet in reset", int'({req_v, fence_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fence_ready == 1'b1, "R1 ready after reset", int'(fence_ready), 1);
        chk(req_v == 4'b0 && !fence_done, "R1 quiet after reset", int'({req_v, fence_done}), 0);

        // R10: done inputs while idle have no effect
        spur = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(fence_ready == 1'b1 && req_v == 4'b0 && !fence_done,
                "R10 idle ignores done", int'({fence_ready, req_v, fence_done}), 32);
        end
        spur = 1'b0;

        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
                run_fence(s, m[0] ? 2 : 0, m[1] ? 1 : 0, m[2] ? 3 : 0, m[3] ? 2 : 0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule